// File: doc/BRIEF.md
# CPU-to-Microcontroller Handshake Port

This block is the glue between an 8-bit microprocessor bus and a slow microcontroller. It lets the two talk without any fixed protocol timing. The microcontroller sets its own pace. The CPU signals it through a request strobe, and it learns whether the microcontroller is ready by reading one status address.

A CPU write to the request address ends on the falling edge of the CPU clock. At that point the block latches the written byte and raises a one-clock REQUEST pulse, which the microcontroller can use as an interrupt source. A CPU read of the status address returns a single byte. Bit 7 holds the microcontroller's acknowledge line, so a bit-test instruction can move it straight into the sign flag. Bit 6 shows that a request is still waiting for an acknowledge.

The microcontroller can also stall the CPU. Its hold request reaches the active-low ready output only while the CPU is addressing this block's window. The whole design runs from a fast system clock and samples the CPU clock as a level.

Top module: `hsk_port`

## Requirements
- R1: After reset, `mcu_req` is 0, `cpu_doe` is 0, `cpu_rdata` is 0 and `cpu_rdy` is 1.
- R2: When `cpu_phi2` falls while the address equals the request address and `cpu_rw` is 0 (write), `mcu_req` is 1 for exactly one clock, on the clock after the fall is sampled.
- R3: The byte on `cpu_wdata` at that fall appears on `mcu_data` with the pulse. It holds there until the next request.
- R4: No pulse is raised, and `mcu_data` does not change, in these cases: a write to any other address, or a read cycle (`cpu_rw`=1) at the request address.
- R5: One clock after the address equals the status address with `cpu_rw`=1, `cpu_doe` is 1 and `cpu_rdata` is {ack, attention, 6'b000000}. The acknowledge is in bit 7, the attention flag in bit 6, and bits 5..0 are zero.
- R6: When the status address is not being read, `cpu_doe` is 0 and `cpu_rdata` is 0 on the next clock.
- R7: `mcu_ack` passes through SYNC_STAGES flip-flops that reset to 0. After reset the status therefore reads not-acknowledged, and a change on `mcu_ack` is not visible in a status read taken one clock later.
- R8: The attention flag is set by each REQUEST pulse. It is cleared when the synchronised acknowledge rises from 0 to 1.
- R9: `cpu_rdy` (0 = stall) is the registered NAND of the window decode and the synchronised `mcu_hold`. A hold asserted while the address is outside the window leaves `cpu_rdy` at 1. A hold asserted while any address inside the window is presented drives `cpu_rdy` to 0.
- R10: While `cpu_rdy` is 0, it stays 0 until the hold is released. A request write whose `cpu_phi2` fall occurs while the CPU is stalled raises no pulse.
- R11: The window holds every address A for which (A & MASK) == (BASE & MASK). The request address is (BASE & MASK) | REQ_OFS, and the status address is (BASE & MASK) | STAT_OFS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_phi2 | input | 1 | CPU clock, sampled as a level |
| cpu_addr | input | ADDR_W | CPU address bus |
| cpu_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Status byte toward the CPU data bus |
| cpu_doe | output | 1 | Data bus output enable |
| cpu_rdy | output | 1 | CPU ready, low stalls the CPU |
| mcu_req | output | 1 | One-clock request pulse to the microcontroller |
| mcu_data | output | 8 | Byte latched by the last request write |
| mcu_ack | input | 1 | Acknowledge from the microcontroller, asynchronous |
| mcu_hold | input | 1 | Hold request from the microcontroller, asynchronous |

## Verification
The bench builds the block with a 16-bit address, BASE 16'h9F60 and MASK 16'hFFF0, REQ_OFS 0, STAT_OFS 1 and two synchroniser stages. These settings give a sixteen-byte window. That window makes the edge addresses 16'h9F6F (inside, but neither register) and 16'h9F70 (just outside) reachable, along with an address that matches only the unmasked bits. Two stages make the acknowledge latency visible in a status read. They also let a request write be stalled, then released, then completed, so the stalled fall can be checked for a missing pulse.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  localparam int DATA_W   = 8;
  localparam int ACK_BIT  = 7;
  localparam int ATTN_BIT = 6;

  typedef enum logic [1:0] {
    ACC_NONE    = 2'd0,
    ACC_REQ_WR  = 2'd1,
    ACC_STAT_RD = 2'd2,
    ACC_OTHER   = 2'd3
  } acc_e;

  function automatic logic [DATA_W-1:0] pack_status(input logic ack, input logic attn);
    logic [DATA_W-1:0] b;
    b = '0;
    b[ACK_BIT]  = ack;
    b[ATTN_BIT] = attn;
    return b;
  endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2+((STAGES==1)?1:0):0], d} >> ((STAGES==1)?0:0);
      end
      assign q = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/hsk_decode.sv
module hsk_decode import hsk_pkg::*; #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE     = '0,
  parameter logic [ADDR_W-1:0] MASK     = '1,
  parameter logic [ADDR_W-1:0] REQ_OFS  = '0,
  parameter logic [ADDR_W-1:0] STAT_OFS = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  output logic              win_hit,
  output acc_e              acc
);

  localparam logic [ADDR_W-1:0] WIN_BASE  = BASE & MASK;
  localparam logic [ADDR_W-1:0] REQ_ADDR  = WIN_BASE | REQ_OFS;
  localparam logic [ADDR_W-1:0] STAT_ADDR = WIN_BASE | STAT_OFS;

  always_comb begin
    win_hit = ((addr & MASK) == WIN_BASE);
    acc     = ACC_NONE;
    if (win_hit) begin
      if (addr == REQ_ADDR && !rw)
        acc = ACC_REQ_WR;
      else if (addr == STAT_ADDR && rw)
        acc = ACC_STAT_RD;
      else
        acc = ACC_OTHER;
    end
  end

endmodule

// File: rtl/hsk_req.sv
module hsk_req #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phi2,
  input  logic          is_req_wr,
  input  logic [DW-1:0] wdata,
  input  logic          go,
  input  logic          ack_s,
  output logic          req,
  output logic [DW-1:0] data,
  output logic          attn
);

  logic phi2_q;
  logic ack_q;
  logic fall_hit;
  logic ack_rise;

  assign fall_hit = phi2_q & ~phi2 & is_req_wr & go;
  assign ack_rise = ack_s & ~ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phi2_q <= 1'b0;
      ack_q  <= 1'b0;
      req    <= 1'b0;
      data   <= '0;
      attn   <= 1'b0;
    end else begin
      phi2_q <= phi2;
      ack_q  <= ack_s;
      req    <= fall_hit;
      if (fall_hit) data <= wdata;
      if (fall_hit)      attn <= 1'b1;
      else if (ack_rise) attn <= 1'b0;
    end
  end

endmodule

// File: rtl/hsk_port.sv
module hsk_port import hsk_pkg::*; #(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE        = 16'h9F60,
  parameter logic [ADDR_W-1:0] MASK        = 16'hFFF0,
  parameter logic [ADDR_W-1:0] REQ_OFS     = 16'h0000,
  parameter logic [ADDR_W-1:0] STAT_OFS    = 16'h0001,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_phi2,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_doe,
  output logic              cpu_rdy,
  output logic              mcu_req,
  output logic [7:0]        mcu_data,
  input  logic              mcu_ack,
  input  logic              mcu_hold
);

  logic win_hit;
  acc_e acc;
  logic ack_s;
  logic hold_s;
  logic attn;

  hsk_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .MASK(MASK),
    .REQ_OFS(REQ_OFS), .STAT_OFS(STAT_OFS)
  ) i_decode (
    .addr(cpu_addr), .rw(cpu_rw), .win_hit(win_hit), .acc(acc)
  );

  hsk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_ack (
    .clk(clk), .rst(rst), .d(mcu_ack), .q(ack_s)
  );

  hsk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_hold (
    .clk(clk), .rst(rst), .d(mcu_hold), .q(hold_s)
  );

  hsk_req #(.DW(DATA_W)) i_req (
    .clk(clk), .rst(rst), .phi2(cpu_phi2),
    .is_req_wr(acc == ACC_REQ_WR), .wdata(cpu_wdata),
    .go(cpu_rdy), .ack_s(ack_s),
    .req(mcu_req), .data(mcu_data), .attn(attn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_doe   <= 1'b0;
      cpu_rdata <= '0;
      cpu_rdy   <= 1'b1;
    end else begin
      cpu_doe   <= (acc == ACC_STAT_RD);
      cpu_rdata <= (acc == ACC_STAT_RD) ? pack_status(ack_s, attn) : '0;
      cpu_rdy   <= ~(win_hit & hold_s);
    end
  end

endmodule

// File: rtl/hsk_port_chk.sv
module hsk_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_rdy,
  input logic       cpu_doe,
  input logic [7:0] cpu_rdata,
  input logic       mcu_req,
  input logic       ack_s,
  input logic       hold_s,
  input logic       win_hit
);

  assert_req_one_clk_R2: assert property (@(posedge clk) disable iff (rst)
    mcu_req |=> !mcu_req);

  assert_req_not_stalled_R10: assert property (@(posedge clk) disable iff (rst)
    mcu_req |-> $past(cpu_rdy));

  assert_bus_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !cpu_doe |-> (cpu_rdata == 8'h00));

  assert_status_low_zero_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_doe |-> (cpu_rdata[5:0] == 6'd0));

  assert_ack_bit_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_doe |-> (cpu_rdata[7] == $past(ack_s)));

  assert_rdy_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !cpu_rdy |-> $past(win_hit && hold_s));

  assert_stall_held_R10: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rdy && win_hit && hold_s) |=> !cpu_rdy);

endmodule

bind hsk_port hsk_port_chk i_chk (
  .clk(clk), .rst(rst), .cpu_rdy(cpu_rdy), .cpu_doe(cpu_doe),
  .cpu_rdata(cpu_rdata), .mcu_req(mcu_req), .ack_s(ack_s),
  .hold_s(hold_s), .win_hit(win_hit)
);

// File: tb/test_hsk_port.sv
module test_hsk_port;

  localparam logic [15:0] BASE = 16'h9F60;
  localparam logic [15:0] MASK = 16'hFFF0;
  localparam logic [15:0] A_REQ  = 16'h9F60;
  localparam logic [15:0] A_STAT = 16'h9F61;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_phi2 = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic cpu_rw = 1'b1;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic cpu_doe, cpu_rdy, mcu_req;
  logic [7:0] mcu_data;
  logic mcu_ack = 1'b0;
  logic mcu_hold = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  hsk_port #(.ADDR_W(16), .BASE(BASE), .MASK(MASK), .REQ_OFS(16'h0000),
             .STAT_OFS(16'h0001), .SYNC_STAGES(2)) i_hsk_port (
    .clk(clk), .rst(rst), .cpu_phi2(cpu_phi2), .cpu_addr(cpu_addr),
    .cpu_rw(cpu_rw), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_doe(cpu_doe), .cpu_rdy(cpu_rdy), .mcu_req(mcu_req),
    .mcu_data(mcu_data), .mcu_ack(mcu_ack), .mcu_hold(mcu_hold)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every pulse must match the oldest expected byte (R2, R3, R4).
  always @(negedge clk) begin
    if (!rst && mcu_req) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected request pulse", mcu_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(mcu_data == e, "R3 request byte", mcu_data, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic park();
    @(negedge clk);
    cpu_addr = 16'h0000; cpu_rw = 1'b1; cpu_phi2 = 1'b0;
  endtask

  task automatic cpu_cycle(input logic [15:0] a, input logic rw, input logic [7:0] d,
                           input bit expect_req);
    @(negedge clk);
    cpu_addr = a; cpu_rw = rw; cpu_wdata = d; cpu_phi2 = 1'b1;
    idle(2);
    @(negedge clk);
    cpu_phi2 = 1'b0;
    if (expect_req) exp_q.push_back(d);
    idle(3);
    park();
  endtask

  task automatic read_status(input logic [7:0] exp, input string tag);
    @(negedge clk);
    cpu_addr = A_STAT; cpu_rw = 1'b1; cpu_phi2 = 1'b1;
    @(posedge clk); #1;
    check(cpu_doe == 1'b1, {tag, " doe"}, cpu_doe, 1);
    check(cpu_rdata == exp, tag, cpu_rdata, exp);
    park();
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(5);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(mcu_req == 1'b0, "R1 req", mcu_req, 0);
    check(cpu_doe == 1'b0, "R1 doe", cpu_doe, 0);
    check(cpu_rdata == 8'h00, "R1 rdata", cpu_rdata, 0);
    check(cpu_rdy == 1'b1, "R1 rdy", cpu_rdy, 1);

    read_status(8'h00, "R7 status after reset");

    // R6: read inside window but not status
    @(negedge clk); cpu_addr = 16'h9F62; cpu_rw = 1'b1;
    @(posedge clk); #1;
    check(cpu_doe == 1'b0 && cpu_rdata == 8'h00, "R6 other read", {cpu_doe, cpu_rdata}, 0);
    park();

    // R2/R3/R8: request write
    cpu_cycle(A_REQ, 1'b0, 8'hA5, 1'b1);
    check(mcu_data == 8'hA5, "R3 latched", mcu_data, 8'hA5);
    read_status(8'h40, "R8 attention set");

    // R4/R11: non-request writes and a read at the request address
    cpu_cycle(16'h9F62, 1'b0, 8'h11, 1'b0);
    cpu_cycle(16'h9F70, 1'b0, 8'h22, 1'b0);
    cpu_cycle(16'h0F60, 1'b0, 8'h33, 1'b0);
    cpu_cycle(A_REQ, 1'b1, 8'h44, 1'b0);
    check(mcu_data == 8'hA5, "R4 data unchanged", mcu_data, 8'hA5);

    // R7: ack not seen one clock later, seen after sync
    @(negedge clk); mcu_ack = 1'b1;
    cpu_addr = A_STAT; cpu_rw = 1'b1;
    @(posedge clk); #1;
    check(cpu_rdata == 8'h40, "R7 ack latency", cpu_rdata, 8'h40);
    park();
    idle(4);
    read_status(8'h80, "R8 ack clears attention");

    @(negedge clk); mcu_ack = 1'b0;
    idle(4);
    cpu_cycle(A_REQ, 1'b0, 8'h3C, 1'b1);
    read_status(8'h40, "R5 status after second request");

    // R9: hold outside and inside window
    @(negedge clk); mcu_hold = 1'b1; cpu_addr = 16'h9F70;
    idle(5); #1;
    check(cpu_rdy == 1'b1, "R9 hold outside window", cpu_rdy, 1);
    @(negedge clk); cpu_addr = 16'h9F6F;
    idle(2); #1;
    check(cpu_rdy == 1'b0, "R9 hold inside window", cpu_rdy, 0);
    @(negedge clk); cpu_addr = 16'h0000;
    idle(2); #1;
    check(cpu_rdy == 1'b1, "R9 leave window", cpu_rdy, 1);

    // R10: stalled write, then release
    @(negedge clk); cpu_addr = A_REQ; cpu_rw = 1'b0; cpu_wdata = 8'h5A; cpu_phi2 = 1'b1;
    idle(3);
    @(negedge clk); cpu_phi2 = 1'b0;
    idle(4); #1;
    check(cpu_rdy == 1'b0, "R10 stall held", cpu_rdy, 0);
    check(mcu_data == 8'h3C, "R10 no request while stalled", mcu_data, 8'h3C);
    @(negedge clk); cpu_phi2 = 1'b1; mcu_hold = 1'b0;
    idle(4); #1;
    check(cpu_rdy == 1'b1, "R10 released", cpu_rdy, 1);
    @(negedge clk); cpu_phi2 = 1'b0; exp_q.push_back(8'h5A);
    idle(3);
    park();
    check(mcu_data == 8'h5A, "R3 data after stall", mcu_data, 8'h5A);

    idle(4);
    check(exp_q.size() == 0, "R2 all requests seen", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule